// File: doc/BRIEF.md
# USB Control Endpoint Status Flags

This block keeps the four status flags of a USB control endpoint for two endpoints side by side: the hub's endpoint 0 (index 0) and the function's endpoint 0 (index 1). A USB transaction engine reports events as single-cycle pulses: a STALL handshake went out, a valid SETUP packet arrived, OUT data was stored, or a control stage finished. A microcontroller reads each endpoint's flags as a read-only byte at its own bus address. It clears flags by writing ones to a separate acknowledge address.

Each endpoint drives a level interrupt request from its flags, gated by per-flag enables. It also drives a NAK-OUT signal back to the engine. That signal holds off new OUT data while an earlier packet is still unread. An early SETUP is not held off: it always lands, and it resets the other flags of its endpoint.

Top module: `ep0_status_regs`

## Requirements
- R1: After reset, both status bytes read 0x00 and `irq` and `out_nak` are both 0.
- R2: Bits 7..4 of a status byte always read 0. A read at any address other than the two status addresses returns 0x00.
- R3: A `ev_stall` pulse sets status bit 3 at the next clock edge. The bit stays set until a one is written to bit 3 of that endpoint's acknowledge address.
- R4: A `ev_setup` pulse sets status bit 2 and clears bits 3, 1 and 0 at the same edge, so the byte reads 0x04. This holds whatever other event pulses arrive in that cycle.
- R5: A `ev_out` pulse sets status bit 1. While bit 1 is set, `out_nak` for that endpoint is 1. A further `ev_out` leaves the byte unchanged.
- R6: Status bit 0 is set by any one of three pulses: `ev_rd_data_done` (control read data stage finished), `ev_stat_nodata_done` (status stage with no data stage finished) or `ev_stat_wr_done` (status stage after a control write finished).
- R7: A bus write to an acknowledge address clears each status bit whose written bit (same position 3..0) is 1. Bits written 0 are left unchanged. A bus write to a status address changes nothing.
- R8: If an event pulse and an acknowledge of the same bit occur in the same cycle, the bit ends up set.
- R9: `irq[e]` is 1 exactly when some flag of endpoint e is set and its enable bit `irq_en[4*e+k]` is 1, where k is the flag's bit position.
- R10: The endpoints are independent. Hub status is at address 0xA0 and its acknowledge at 0xA2. Function status is at 0xA1 and its acknowledge at 0xA3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_stall | input | 2 | STALL sent pulse, per endpoint |
| ev_setup | input | 2 | Valid SETUP received pulse, per endpoint |
| ev_out | input | 2 | OUT data stored pulse, per endpoint |
| ev_rd_data_done | input | 2 | Control read data stage done, per endpoint |
| ev_stat_nodata_done | input | 2 | No-data status stage done, per endpoint |
| ev_stat_wr_done | input | 2 | Status stage after control write done, per endpoint |
| irq_en | input | 8 | Interrupt enables, 4 bits per endpoint |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| irq | output | 2 | Interrupt request, per endpoint |
| out_nak | output | 2 | NAK OUT tokens, per endpoint |

## Verification
A flag that is stuck, lost or set in the wrong place shows up in the status byte one cycle after the event or write that should have changed it. The same flag error also shows on `irq` and, for bit 1, on `out_nak`, with no further delay. Errors in address decoding move a change onto the wrong endpoint's byte or the wrong bits. Each test therefore reads both endpoints after every step. Errors in set/clear ordering only show when an event and an acknowledge share a cycle, so that collision is driven on purpose.

// File: rtl/ep0_status_regs.sv
module ep0_status_regs #(
  parameter int          NUM_EP   = 2,
  parameter int          ADDR_W   = 8,
  parameter int          FLAG_W   = 4,
  parameter logic [7:0]  HUB_STAT = 8'hA0,
  parameter logic [7:0]  FUN_STAT = 8'hA1,
  parameter logic [7:0]  HUB_ACK  = 8'hA2,
  parameter logic [7:0]  FUN_ACK  = 8'hA3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EP-1:0]        ev_stall,
  input  logic [NUM_EP-1:0]        ev_setup,
  input  logic [NUM_EP-1:0]        ev_out,
  input  logic [NUM_EP-1:0]        ev_rd_data_done,
  input  logic [NUM_EP-1:0]        ev_stat_nodata_done,
  input  logic [NUM_EP-1:0]        ev_stat_wr_done,
  input  logic [NUM_EP*FLAG_W-1:0] irq_en,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  output logic [NUM_EP-1:0]        irq,
  output logic [NUM_EP-1:0]        out_nak
);

  localparam int B_STALL = 3;
  localparam int B_SETUP = 2;
  localparam int B_OUT   = 1;
  localparam int B_TX    = 0;

  logic [NUM_EP-1:0][FLAG_W-1:0] flags_q;
  logic [NUM_EP-1:0]             stat_hit;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(e == 0 ? HUB_STAT : FUN_STAT);
    localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(e == 0 ? HUB_ACK  : FUN_ACK);

    logic [FLAG_W-1:0] set_v, clr_v;
    logic              ack_hit;

    assign ack_hit     = bus_wr && (bus_addr == ACK_A);
    assign clr_v       = ack_hit ? bus_wdata[FLAG_W-1:0] : '0;
    assign set_v       = {ev_stall[e], 1'b0, ev_out[e],
                          ev_rd_data_done[e] | ev_stat_nodata_done[e] | ev_stat_wr_done[e]};
    assign stat_hit[e] = (bus_addr == STAT_A);

    always_ff @(posedge clk) begin
      if (!rst_n)
        flags_q[e] <= '0;
      else if (ev_setup[e])
        flags_q[e] <= FLAG_W'(1) << B_SETUP;
      else
        flags_q[e] <= (flags_q[e] & ~clr_v) | set_v;
    end

    assign irq[e]     = |(flags_q[e] & irq_en[e*FLAG_W +: FLAG_W]);
    assign out_nak[e] = flags_q[e][B_OUT];

    AST_SETUP_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      ev_setup[e] |=> bus_rdata == 8'h04 || !stat_hit[e] || flags_q[e] == 4'b0100); // R4
    AST_STALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stall[e] && !ev_setup[e]) |=> flags_q[e][B_STALL]); // R3
    AST_OUT_NAKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_out[e] && !ev_setup[e]) |=> out_nak[e]); // R5
    AST_TX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ((ev_rd_data_done[e] || ev_stat_nodata_done[e] || ev_stat_wr_done[e]) && !ev_setup[e])
        |=> flags_q[e][B_TX]); // R6
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_hit && !ev_setup[e] && set_v == '0) |=> $stable(flags_q[e])); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && bus_wdata[B_STALL] && !ev_stall[e] && !ev_setup[e]) |=> !flags_q[e][B_STALL]); // R7
  end

  always_comb begin
    bus_rdata = '0;
    for (int e = 0; e < NUM_EP; e++)
      if (stat_hit[e]) bus_rdata = {{(8-FLAG_W){1'b0}}, flags_q[e]};
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:4] == 4'h0); // R2
  AST_ONE_STAT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_hit)); // R10

endmodule

// File: tb/test_ep0_status_regs.sv
module test_ep0_status_regs;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] ev_stall = 0, ev_setup = 0, ev_out = 0;
  logic [1:0] ev_rd = 0, ev_nd = 0, ev_wr = 0;
  logic [7:0] irq_en = 0;
  logic [7:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [1:0] irq, out_nak;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  ep0_status_regs i_ep0_status_regs (
    .clk(clk), .rst_n(rst_n),
    .ev_stall(ev_stall), .ev_setup(ev_setup), .ev_out(ev_out),
    .ev_rd_data_done(ev_rd), .ev_stat_nodata_done(ev_nd), .ev_stat_wr_done(ev_wr),
    .irq_en(irq_en), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .out_nak(out_nak));

  localparam logic [7:0] HS = 8'hA0, FS = 8'hA1, HA = 8'hA2, FA = 8'hA3;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic chk_rd(string req, logic [7:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  // kind: 0 stall, 1 setup, 2 out, 3 rd data, 4 no-data status, 5 status after write
  task automatic ev(int ep, int kind);
    case (kind)
      0: ev_stall[ep] = 1;
      1: ev_setup[ep] = 1;
      2: ev_out[ep]   = 1;
      3: ev_rd[ep]    = 1;
      4: ev_nd[ep]    = 1;
      default: ev_wr[ep] = 1;
    endcase
    @(negedge clk);
    ev_stall = 0; ev_setup = 0; ev_out = 0; ev_rd = 0; ev_nd = 0; ev_wr = 0;
  endtask

  task automatic t_reset;
    chk_rd("R1 hub", HS, 8'h00);
    chk_rd("R1 fun", FS, 8'h00);
    chk("R1 irq", {6'b0, irq}, 8'h00);
    chk("R1 nak", {6'b0, out_nak}, 8'h00);
  endtask

  task automatic t_stall;
    ev(0, 0);
    chk_rd("R3 set", HS, 8'h08);
    chk_rd("R10 fun untouched", FS, 8'h00);
    wr(HA, 8'h00);
    chk_rd("R7 zero ack keeps", HS, 8'h08);
    wr(HS, 8'hFF);
    chk_rd("R7 status write ignored", HS, 8'h08);
    wr(FA, 8'h08);
    chk_rd("R10 other ack ignored", HS, 8'h08);
    wr(HA, 8'h08);
    chk_rd("R3 ack clears", HS, 8'h00);
  endtask

  task automatic t_out;
    ev(1, 2);
    chk_rd("R5 set", FS, 8'h02);
    chk("R5 nak", {6'b0, out_nak}, 8'h02);
    ev(1, 2);
    chk_rd("R5 repeat", FS, 8'h02);
    wr(FA, 8'h02);
    chk_rd("R7 ack out", FS, 8'h00);
    chk("R5 nak off", {6'b0, out_nak}, 8'h00);
  endtask

  task automatic t_tx;
    for (int k = 3; k <= 5; k++) begin
      ev(0, k);
      chk_rd($sformatf("R6 kind %0d", k), HS, 8'h01);
      wr(HA, 8'h01);
      chk_rd("R6 cleared", HS, 8'h00);
    end
  endtask

  task automatic t_setup;
    ev(1, 0); ev(1, 2); ev(1, 3);
    chk_rd("R4 pre", FS, 8'h0B);
    ev_setup[1] = 1; ev_stall[1] = 1; ev_out[1] = 1;
    @(negedge clk);
    ev_setup = 0; ev_stall = 0; ev_out = 0;
    chk_rd("R4 wipes", FS, 8'h04);
    chk("R4 nak off", {6'b0, out_nak}, 8'h00);
    wr(FA, 8'h04);
    chk_rd("R4 ack", FS, 8'h00);
  endtask

  task automatic t_reserved;
    ev(0, 0); ev(0, 2);
    wr(HA, 8'hF0);
    chk_rd("R2 high bits", HS, 8'h0A);
    chk_rd("R2 unmapped", 8'h55, 8'h00);
    chk_rd("R2 ack addr reads 0", HA, 8'h00);
    wr(HA, 8'hFF);
    chk_rd("R7 ack all", HS, 8'h00);
  endtask

  task automatic t_race;
    ev_stall[0] = 1; bus_addr = HA; bus_wdata = 8'h08; bus_wr = 1;
    @(negedge clk);
    ev_stall = 0; bus_wr = 0; bus_wdata = 0;
    chk_rd("R8 set wins", HS, 8'h08);
    wr(HA, 8'h08);
    chk_rd("R8 cleared", HS, 8'h00);
  endtask

  task automatic t_irq;
    irq_en = 8'h00;
    ev(0, 3);
    #1 chk("R9 disabled", {6'b0, irq}, 8'h00);
    irq_en = 8'h01;
    #1 chk("R9 enabled", {6'b0, irq}, 8'h01);
    irq_en = 8'h10;
    #1 chk("R9 other ep enable", {6'b0, irq}, 8'h00);
    irq_en = 8'h21;
    ev(1, 2);
    chk("R9 both", {6'b0, irq}, 8'h03);
    wr(HA, 8'h01);
    chk("R9 hub acked", {6'b0, irq}, 8'h02);
    wr(FA, 8'h02);
    chk("R9 none", {6'b0, irq}, 8'h00);
    irq_en = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stall();
    t_out();
    t_tx();
    t_setup();
    t_reserved();
    t_race();
    t_irq();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule